// File: doc/BRIEF.md
# Cascadable Latched Magnitude Comparator

This block compares two words, a held operand A and a live operand B, and reports whether A is above or below B. The A word enters through a hold register with a transparent bypass. While the capture enable is high the comparison uses the live A inputs and the register tracks them. While the enable is low the comparison uses the word captured on the last clock edge with the enable high. A mode input selects the comparison type. With mode high the words are compared as unsigned numbers. With mode low they are compared as two's-complement numbers, and the top bit is the sign.

The block has two decision outputs, above and below. When the words differ, the outputs give the local decision and the chain inputs have no effect. When the words are equal, each output copies the matching chain input. To compare longer words, connect the outputs of the stage that holds the less significant slice to the chain inputs of the next more significant stage. Tie both chain inputs of the lowest stage low. Then both outputs low means the whole words are equal. Only the top stage may use signed mode.

Top module: `cascade_cmp`

## Requirements
- R1: After a synchronous active-low reset the held A word is zero. With the enable low, the comparison then uses A = 0.
- R2: While `cap_en` is high, the outputs follow the live `a_in` in the same cycle, with no register delay. The held word loads `a_in` on every clock edge while `cap_en` is high.
- R3: While `cap_en` is low, the held word stays unchanged whatever `a_in` does, and the outputs use the held word.
- R4: With `unsigned_mode` = 1, A and B are compared as unsigned numbers (for example 0x80 is above 0x7F).
- R5: With `unsigned_mode` = 0, A and B are compared as two's-complement numbers with bit WIDTH-1 as the sign (for example 0x80 is below 0x7F).
- R6: When A differs from B, exactly one of `above_out` and `below_out` is high, whatever the chain inputs are.
- R7: When A equals B, `above_out` equals `above_in` and `below_out` equals `below_in`.
- R8: Two stages chained low slice to high slice, with the lower stage in unsigned mode and its chain inputs tied low, give the correct 16-bit comparison. Both outputs low means the 16-bit words are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the held A word |
| cap_en | input | 1 | 1: bypass and capture A; 0: hold A |
| unsigned_mode | input | 1 | 1: unsigned compare; 0: two's-complement compare |
| a_in | input | WIDTH | Operand A (held side) |
| b_in | input | WIDTH | Operand B (live) |
| above_in | input | 1 | Chain input: lower slice says A > B |
| below_in | input | 1 | Chain input: lower slice says A < B |
| above_out | output | 1 | A > B decision for this and lower slices |
| below_out | output | 1 | A < B decision for this and lower slices |

## Verification
The assertion that the two outputs are never both high assumes the chain inputs are never both high together. The lowest stage has both tied low, and each higher stage is driven by a lower stage that obeys the same rule. The bench therefore draws the chain-input pair only from the three legal codes. The random stimulus mixes live and held operands, and includes directed words that sit on the sign boundary, where signed and unsigned results disagree. The chained pair always keeps its lower stage in unsigned mode.

// File: rtl/cascade_cmp_pkg.sv
package cascade_cmp_pkg;
    typedef enum logic [1:0] {
        REL_EQ = 2'b00,
        REL_LT = 2'b01,
        REL_GT = 2'b10
    } rel_e;
endpackage

// File: rtl/cmp_hold_reg.sv
module cmp_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] eff_out
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (cap_en) hold_d.word = d_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign eff_out = cap_en ? d_in : hold_q.word;

    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && $past(rst_n)) |=> (!$past(cap_en) -> $stable(hold_q.word)));
    p_bypass_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> (eff_out == d_in));
endmodule

// File: rtl/cmp_core.sv
module cmp_core
    import cascade_cmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             unsigned_mode,
    input  logic [WIDTH-1:0] a_val,
    input  logic [WIDTH-1:0] b_val,
    output rel_e             rel
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] a_x, b_x;

    // Flipping the sign bit maps two's-complement order onto unsigned order.
    always_comb begin
        a_x = a_val;
        b_x = b_val;
        if (!unsigned_mode) begin
            a_x[MSB] = ~a_val[MSB];
            b_x[MSB] = ~b_val[MSB];
        end
        if (a_x > b_x)      rel = REL_GT;
        else if (a_x < b_x) rel = REL_LT;
        else                rel = REL_EQ;
    end

    p_eq_iff_same_r7: assert final ((rel == REL_EQ) == (a_val == b_val));
endmodule

// File: rtl/cmp_chain_mux.sv
module cmp_chain_mux
    import cascade_cmp_pkg::*;
(
    input  rel_e rel,
    input  logic above_in,
    input  logic below_in,
    output logic above_out,
    output logic below_out
);
    always_comb begin
        unique case (rel)
            REL_GT:  begin above_out = 1'b1;     below_out = 1'b0;     end
            REL_LT:  begin above_out = 1'b0;     below_out = 1'b1;     end
            default: begin above_out = above_in; below_out = below_in; end
        endcase
    end
endmodule

// File: rtl/cascade_cmp.sv
module cascade_cmp
    import cascade_cmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             unsigned_mode,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             above_in,
    input  logic             below_in,
    output logic             above_out,
    output logic             below_out
);
    logic [WIDTH-1:0] a_eff;
    rel_e             rel;

    cmp_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .d_in(a_in), .eff_out(a_eff)
    );

    cmp_core #(.WIDTH(WIDTH)) u_core (
        .unsigned_mode(unsigned_mode), .a_val(a_eff), .b_val(b_in), .rel(rel)
    );

    cmp_chain_mux u_mux (
        .rel(rel), .above_in(above_in), .below_in(below_in),
        .above_out(above_out), .below_out(below_out)
    );

    p_differ_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_eff != b_in) |-> (above_out ^ below_out));
    p_equal_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_eff == b_in) |-> (above_out == above_in && below_out == below_in));
    p_never_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(above_in && below_in) |-> !(above_out && below_out));
endmodule

// File: tb/cascade_cmp_bench.sv
module cascade_cmp_bench;
    localparam int W = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic cap_en = 0, umode = 1;
    logic [W-1:0] a = 0, b = 0;
    logic gi = 0, li = 0;
    logic go, lo;

    // Two-stage chain: lo stage unsigned, hi stage selectable.
    logic c_en = 1, c_umode = 1;
    logic [15:0] ca = 0, cb = 0;
    logic mid_g, mid_l, cg, cl;

    int total = 0, bad = 0;
    logic [W-1:0] held;

    always #5 clk = ~clk;

    cascade_cmp #(.WIDTH(W)) u_cascade_cmp (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .unsigned_mode(umode),
        .a_in(a), .b_in(b), .above_in(gi), .below_in(li),
        .above_out(go), .below_out(lo));

    cascade_cmp #(.WIDTH(8)) u_lo (
        .clk(clk), .rst_n(rst_n), .cap_en(c_en), .unsigned_mode(1'b1),
        .a_in(ca[7:0]), .b_in(cb[7:0]), .above_in(1'b0), .below_in(1'b0),
        .above_out(mid_g), .below_out(mid_l));
    cascade_cmp #(.WIDTH(8)) u_hi (
        .clk(clk), .rst_n(rst_n), .cap_en(c_en), .unsigned_mode(c_umode),
        .a_in(ca[15:8]), .b_in(cb[15:8]), .above_in(mid_g), .below_in(mid_l),
        .above_out(cg), .below_out(cl));

    function automatic logic [1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic um, input logic g, input logic l);
        logic gt, lt;
        if (um) begin gt = x > y; lt = x < y; end
        else begin gt = $signed(x) > $signed(y); lt = $signed(x) < $signed(y); end
        if (gt) return 2'b10;
        if (lt) return 2'b01;
        return {g, l};
    endfunction

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Drive after the falling edge, sample just before the next rising edge.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic drive(input logic en, input logic um, input logic [W-1:0] x,
                         input logic [W-1:0] y, input logic [1:0] c);
        @(negedge clk);
        cap_en = en; umode = um; a = x; b = y; {gi, li} = c;
        if (en) held = x;
        #3;
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [1:0] cc;
        logic [15:0] x16, y16;
        void'($urandom(32'd1234));
        held = 0;
        repeat (3) step();
        rst_n = 1;
        // R1: held word zero after reset
        drive(0, 1, 8'h55, 8'h00, 2'b00);
        chk("R1 reset clear", {go, lo}, 2'b00);
        drive(0, 1, 8'h55, 8'h01, 2'b00);
        chk("R1 held zero below", {go, lo}, 2'b01);
        // R4/R5 sign boundary
        drive(1, 1, 8'h80, 8'h7F, 2'b00);
        chk("R4 unsigned 80>7F", {go, lo}, 2'b10);
        drive(1, 0, 8'h80, 8'h7F, 2'b00);
        chk("R5 signed 80<7F", {go, lo}, 2'b01);
        drive(1, 0, 8'hFF, 8'h00, 2'b00);
        chk("R5 signed -1<0", {go, lo}, 2'b01);
        drive(1, 1, 8'hFF, 8'h00, 2'b00);
        chk("R4 unsigned FF>00", {go, lo}, 2'b10);
        // R7 pass-through on equality
        drive(1, 0, 8'h3C, 8'h3C, 2'b10);
        chk("R7 equal pass gt", {go, lo}, 2'b10);
        drive(1, 1, 8'h3C, 8'h3C, 2'b01);
        chk("R7 equal pass lt", {go, lo}, 2'b01);
        // R6 chain inputs ignored when differing
        drive(1, 1, 8'h10, 8'h20, 2'b10);
        chk("R6 ignore chain", {go, lo}, 2'b01);
        // R2 capture then R3 hold
        drive(1, 1, 8'h90, 8'h90, 2'b00);
        chk("R2 live bypass", {go, lo}, 2'b00);
        drive(0, 1, 8'h01, 8'h90, 2'b00);
        chk("R3 hold keeps 90", {go, lo}, 2'b00);
        drive(0, 1, 8'hFF, 8'h8F, 2'b00);
        chk("R3 hold ignores live A", {go, lo}, 2'b10);
        drive(0, 0, 8'h00, 8'h8F, 2'b00);
        chk("R3 hold signed", {go, lo}, 2'b10);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic en, um;
            logic [W-1:0] x, y;
            en = ($urandom % 3) != 0;
            um = $urandom;
            x = $urandom;
            y = ($urandom % 4 == 0) ? (en ? x : held) : W'($urandom);
            cc = 2'($urandom % 3);
            drive(en, um, x, y, cc);
            chk("R6/R7 random", {go, lo}, model(en ? x : held, y, um, cc[1], cc[0]));
        end
        // R8 chained 16-bit
        for (int i = 0; i < 200; i++) begin
            logic um;
            um = $urandom;
            x16 = $urandom;
            y16 = (i % 5 == 0) ? x16 : ((i % 5 == 1) ? {x16[15:8], 8'($urandom)} : 16'($urandom));
            @(negedge clk);
            c_umode = um; ca = x16; cb = y16;
            #3;
            if (um) chk("R8 chain unsigned", {cg, cl},
                        (x16 > y16) ? 2'b10 : (x16 < y16) ? 2'b01 : 2'b00);
            else    chk("R8 chain signed", {cg, cl},
                        ($signed(x16) > $signed(y16)) ? 2'b10 :
                        ($signed(x16) < $signed(y16)) ? 2'b01 : 2'b00);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule